// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This block lets a small 8-bit processor reach external memory over a narrow bus. The low address byte and the data byte share one 8-bit port. A second 8-bit port can carry four or eight more address bits, or none. Each access runs in three phases. First the address is placed on the shared port and the address strobe is pulsed. Then the shared port turns around: it is released on reads and carries write data on writes, while the data strobe is low. Finally both strobes are released. Read data goes back to the processor.

A configuration byte turns on the multiplexed mode and selects how many high address lanes are used. Lanes that are not selected keep their general-purpose output value. Each write of the configuration arms a guard. No bus cycle may start until the processor has signalled one full instruction slot after that write. A request made earlier is refused, and the block raises a one-cycle error flag. While a cycle is in progress, `busy` is high and further requests are ignored.

Top module: `ext_bus_ctrl`

## Requirements
- R1: After reset, `as_n`, `ds_n` and `rw_n` are 1, `ad_oe`, `busy`, `err` and `rd_valid` are 0, `hi_out` equals `hi_gpio`, and the configuration byte is 0, so the multiplexed mode is off.
- R2: Multiplexed mode is on only when configuration bit 4 is 1 and bit 3 is 0. A request made while it is off is refused: `err` is 1 for one cycle in the following cycle, and no strobe is asserted.
- R3: A configuration write arms a guard of `GUARD_SLOTS` (default 1) `slot_tick` pulses. A request while the guard is armed is refused and `err` is pulsed as in R2. After the guard has elapsed, a request is accepted.
- R4: In the cycle after a request is accepted, `busy` = 1, `as_n` = 0 for `ADDR_CYC` cycles, `ad_oe` = 1, `ad_out` = `req_addr[7:0]`, and `rw_n` = 0 for a write or 1 for a read. The address strobe and the data strobe are never low together.
- R5: For a write, `ds_n` = 0 for `DATA_CYC` cycles right after the address phase, with `ad_oe` = 1 and `ad_out` = `req_wdata`.
- R6: For a read, `ad_oe` = 0 while `ds_n` = 0. `rd_data` takes the value of `ad_in` at the clock edge that ends the data strobe. `rd_valid` is 1 for exactly the one following cycle.
- R7: After the data phase comes one end cycle with both strobes at 1 and `ad_oe` = 0. `busy` then falls, so `busy` stays high for `ADDR_CYC+DATA_CYC+1` cycles.
- R8: Configuration bits [1:0] select the high lanes while `busy` = 1. 00 selects none, so `hi_out` = `hi_gpio`. 01 selects four lanes: `hi_out[3:0]` = `req_addr[11:8]` and `hi_out[7:4]` = `hi_gpio[7:4]`. 10 or 11 selects eight lanes: `hi_out` = `req_addr[15:8]`. While idle, `hi_out` = `hi_gpio`.
- R9: A request made while `busy` = 1 is ignored. It raises no `err` and starts no extra cycle.
- R10: If a configuration write and a `slot_tick` come in the same cycle, the write takes effect and the guard stays armed. A request made in the same cycle as a configuration write is refused with `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte (bit 4/3 mode, bits 1:0 high lanes) |
| slot_tick | input | 1 | One pulse per completed instruction slot |
| req_valid | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Bus cycle in progress |
| rd_data | output | 8 | Captured read data |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is new |
| err | output | 1 | One-cycle pulse for a refused request |
| ad_in | input | 8 | Shared port input value |
| ad_out | output | 8 | Shared port output value |
| ad_oe | output | 1 | Shared port output enable |
| hi_gpio | input | 8 | General-purpose value for the high port |
| hi_out | output | 8 | High port output |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | 1 = read, 0 = write |

## Verification
Two groups of events can land on the same clock edge. A configuration write can coincide with the `slot_tick` that would otherwise release the guard. A configuration write can also coincide with an access request. The bench drives both coincidences from one negative edge. It then checks that `err` pulses and that neither strobe falls. It also checks that one further tick is enough to let a bus cycle start. A third case holds `req_valid` high through the data and end phases of a running cycle. That request must be ignored, with `err` staying low.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_END  = 2'd3
    } bus_phase_e;

    typedef enum logic [1:0] {
        HI_OFF      = 2'd0,
        HI_NIBBLE   = 2'd1,
        HI_BYTE     = 2'd2,
        HI_BYTE_ALT = 2'd3
    } hi_width_e;

    // Shared port carries address/data only with bit 4 set and bit 3 clear
    function automatic logic mux_mode_on(input logic [7:0] cfg);
        return cfg[4] & ~cfg[3];
    endfunction

    function automatic hi_width_e hi_width_of(input logic [7:0] cfg);
        return hi_width_e'(cfg[1:0]);
    endfunction

endpackage

// File: rtl/ext_bus_cfg.sv
module ext_bus_cfg
    import ext_bus_pkg::*;
#(
    parameter int GUARD_SLOTS = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cfg_we,
    input  logic [7:0] cfg_wdata,
    input  logic      slot_tick,
    output logic      mux_on,
    output hi_width_e hi_width,
    output logic      guard_active
);

    localparam int GW = $clog2(GUARD_SLOTS + 1);

    typedef struct packed {
        logic [7:0]    cfg;
        logic [GW-1:0] guard;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_we) begin
            // a write re-arms the guard even if a tick lands in the same cycle
            st_d.cfg   = cfg_wdata;
            st_d.guard = GW'(GUARD_SLOTS);
        end else if (slot_tick && (st_q.guard != '0)) begin
            st_d.guard = st_q.guard - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mux_on       = mux_mode_on(st_q.cfg);
    assign hi_width     = hi_width_of(st_q.cfg);
    assign guard_active = (st_q.guard != '0);

endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
    import ext_bus_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int ADDR_CYC = 1,
    parameter int DATA_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              mux_on,
    input  logic              guard_active,
    input  logic              cfg_we,
    input  hi_width_e         hi_width,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw_n,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output hi_width_e         lane_width
);

    localparam int CNT_MAX = (ADDR_CYC > DATA_CYC) ? ADDR_CYC : DATA_CYC;
    localparam int CW      = $clog2(CNT_MAX) + 1;

    typedef struct packed {
        bus_phase_e        phase;
        logic [CW-1:0]     cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              we;
        hi_width_e         width;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              err;
    } seq_state_t;

    seq_state_t st_d, st_q;
    logic       start_ok;

    assign start_ok = mux_on && !guard_active && !cfg_we;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = 1'b0;
        st_d.err    = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    if (start_ok) begin
                        st_d.phase = PH_ADDR;
                        st_d.cnt   = '0;
                        st_d.addr  = req_addr;
                        st_d.wdata = req_wdata;
                        st_d.we    = req_we;
                        st_d.width = hi_width;
                    end else begin
                        st_d.err = 1'b1;
                    end
                end
            end
            PH_ADDR: begin
                if (st_q.cnt == CW'(ADDR_CYC - 1)) begin
                    st_d.phase = PH_DATA;
                    st_d.cnt   = '0;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_DATA: begin
                if (st_q.cnt == CW'(DATA_CYC - 1)) begin
                    st_d.phase = PH_END;
                    st_d.cnt   = '0;
                    if (!st_q.we) begin
                        // sampled on the edge that releases the data strobe
                        st_d.rdata  = ad_in;
                        st_d.rvalid = 1'b1;
                    end
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_END: begin
                st_d.phase = PH_IDLE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic in_addr, in_data;
    assign in_addr = (st_q.phase == PH_ADDR);
    assign in_data = (st_q.phase == PH_DATA);

    assign busy       = (st_q.phase != PH_IDLE);
    assign as_n       = !in_addr;
    assign ds_n       = !in_data;
    assign ad_oe      = in_addr || (in_data && st_q.we);
    assign ad_out     = in_addr ? st_q.addr[DATA_W-1:0] :
                        (in_data && st_q.we) ? st_q.wdata : '0;
    assign rw_n       = !(busy && st_q.we);
    assign rd_data    = st_q.rdata;
    assign rd_valid   = st_q.rvalid;
    assign err        = st_q.err;
    assign addr_hi    = st_q.addr[ADDR_W-1:DATA_W];
    assign lane_width = st_q.width;

endmodule

// File: rtl/ext_bus_hiport.sv
module ext_bus_hiport
    import ext_bus_pkg::*;
#(
    parameter int HI_W = 8
) (
    input  logic            busy,
    input  hi_width_e       width,
    input  logic [HI_W-1:0] addr_hi,
    input  logic [HI_W-1:0] gpio,
    output logic [HI_W-1:0] hi_out
);

    localparam int NIB_W = HI_W / 2;

    logic full_en, nib_en;
    assign full_en = busy && ((width == HI_BYTE) || (width == HI_BYTE_ALT));
    assign nib_en  = busy && (width == HI_NIBBLE);

    for (genvar i = 0; i < HI_W; i++) begin : g_lane
        localparam bit LOW_LANE = (i < NIB_W);
        logic lane_en;
        assign lane_en   = full_en || (nib_en && LOW_LANE);
        assign hi_out[i] = lane_en ? addr_hi[i] : gpio[i];
    end

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ext_bus_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int ADDR_CYC    = 1,
    parameter int DATA_CYC    = 2,
    parameter int GUARD_SLOTS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [7:0]        cfg_wdata,
    input  logic              slot_tick,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid,
    output logic              err,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [ADDR_W-DATA_W-1:0] hi_gpio,
    output logic [ADDR_W-DATA_W-1:0] hi_out,
    output logic              as_n,
    output logic              ds_n,
    output logic              rw_n
);

    localparam int HI_W = ADDR_W - DATA_W;

    logic            mux_on;
    logic            guard_active;
    hi_width_e       cfg_width;
    hi_width_e       lane_width;
    logic [HI_W-1:0] addr_hi;

    ext_bus_cfg #(
        .GUARD_SLOTS(GUARD_SLOTS)
    ) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .slot_tick   (slot_tick),
        .mux_on      (mux_on),
        .hi_width    (cfg_width),
        .guard_active(guard_active)
    );

    ext_bus_seq #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .ADDR_CYC(ADDR_CYC),
        .DATA_CYC(DATA_CYC)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_we      (req_we),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .mux_on      (mux_on),
        .guard_active(guard_active),
        .cfg_we      (cfg_we),
        .hi_width    (cfg_width),
        .ad_in       (ad_in),
        .ad_out      (ad_out),
        .ad_oe       (ad_oe),
        .as_n        (as_n),
        .ds_n        (ds_n),
        .rw_n        (rw_n),
        .busy        (busy),
        .rd_data     (rd_data),
        .rd_valid    (rd_valid),
        .err         (err),
        .addr_hi     (addr_hi),
        .lane_width  (lane_width)
    );

    ext_bus_hiport #(
        .HI_W(HI_W)
    ) u_hiport (
        .busy   (busy),
        .width  (lane_width),
        .addr_hi(addr_hi),
        .gpio   (hi_gpio),
        .hi_out (hi_out)
    );

endmodule

// File: rtl/ext_bus_ctrl_chk.sv
module ext_bus_ctrl_chk #(
    parameter int HI_W = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            rd_valid,
    input logic            err,
    input logic            ad_oe,
    input logic [HI_W-1:0] hi_gpio,
    input logic [HI_W-1:0] hi_out,
    input logic            as_n,
    input logic            ds_n,
    input logic            rw_n
);

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n && !ds_n)); // R4

    AST_DS_AFTER_AS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ds_n) |-> $past(!as_n)); // R4

    AST_WRITE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !rw_n) |-> ad_oe); // R5

    AST_READ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rw_n) |-> !ad_oe); // R6

    AST_RDV_AFTER_DS: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (ds_n && $past(!ds_n))); // R6

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (as_n && ds_n && !ad_oe && rw_n)); // R7

    AST_IDLE_GPIO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (hi_out == hi_gpio)); // R8

    AST_ERR_NO_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && as_n)); // R3

endmodule

bind ext_bus_ctrl ext_bus_ctrl_chk #(
    .HI_W(ADDR_W - DATA_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .rd_valid(rd_valid),
    .err     (err),
    .ad_oe   (ad_oe),
    .hi_gpio (hi_gpio),
    .hi_out  (hi_out),
    .as_n    (as_n),
    .ds_n    (ds_n),
    .rw_n    (rw_n)
);

// File: tb/ext_bus_ctrl_test.sv
`timescale 1ns/100ps
module ext_bus_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        slot_tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, rd_valid, err, ad_oe, as_n, ds_n, rw_n;
    logic [7:0]  rd_data, ad_out, hi_out;
    logic [7:0]  ad_in = '0;
    logic [7:0]  hi_gpio = 8'hA5;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    ext_bus_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .slot_tick(slot_tick), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
        .rd_data(rd_data), .rd_valid(rd_valid), .err(err), .ad_in(ad_in),
        .ad_out(ad_out), .ad_oe(ad_oe), .hi_gpio(hi_gpio), .hi_out(hi_out),
        .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_hi(input logic [1:0] w, input logic [7:0] a, input logic [7:0] g);
        case (w)
            2'b00:   return g;
            2'b01:   return {g[7:4], a[3:0]};
            default: return a;
        endcase
    endfunction

    task automatic write_cfg(input logic [7:0] v, input bit with_tick);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v; slot_tick = with_tick;
        @(negedge clk);
        cfg_we = 1'b0; slot_tick = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        slot_tick = 1'b1;
        @(negedge clk);
        slot_tick = 1'b0;
    endtask

    // request that must be refused: err next cycle, no cycle started
    task automatic expect_refused(input string tag);
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " err pulse"}, err, 1'b1);
        chk({tag, " no busy"}, busy, 1'b0);
        chk({tag, " no strobe"}, {as_n, ds_n}, 2'b11);
        @(negedge clk);
        chk({tag, " err one cycle"}, err, 1'b0);
    endtask

    // full bus cycle with per-phase checks; caller sits on a negedge
    task automatic bus_cycle(input bit we, input logic [15:0] a, input logic [7:0] wd,
                             input logic [7:0] rv, input logic [1:0] w);
        req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R4 busy", busy, 1'b1);
        chk("R4 as_n", as_n, 1'b0);
        chk("R4 ds_n high in addr", ds_n, 1'b1);
        chk("R4 ad_oe", ad_oe, 1'b1);
        chk("R4 ad_out addr", ad_out, a[7:0]);
        chk("R4 rw_n", rw_n, !we);
        chk("R8 hi_out", hi_out, exp_hi(w, a[15:8], hi_gpio));
        if (!we) ad_in = rv;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R5 ds_n low", ds_n, 1'b0);
            chk("R4 as_n high in data", as_n, 1'b1);
            chk("R8 hi_out held", hi_out, exp_hi(w, a[15:8], hi_gpio));
            if (we) begin
                chk("R5 ad_oe", ad_oe, 1'b1);
                chk("R5 ad_out data", ad_out, wd);
            end else begin
                chk("R6 ad_oe off", ad_oe, 1'b0);
                chk("R6 rw_n", rw_n, 1'b1);
            end
        end
        @(negedge clk);
        if (!we) ad_in = ~rv;
        chk("R7 strobes off", {as_n, ds_n}, 2'b11);
        chk("R7 ad_oe off", ad_oe, 1'b0);
        chk("R7 busy end", busy, 1'b1);
        chk("R6 rd_valid", rd_valid, !we);
        if (!we) chk("R6 rd_data", rd_data, rv);
        @(negedge clk);
        chk("R7 busy low", busy, 1'b0);
        chk("R6 rd_valid one cycle", rd_valid, 1'b0);
        chk("R8 hi_out idle", hi_out, hi_gpio);
        if (!we) chk("R6 rd_data held", rd_data, rv);
    endtask

    task automatic t_reset();
        chk("R1 as_n", as_n, 1'b1);
        chk("R1 ds_n", ds_n, 1'b1);
        chk("R1 rw_n", rw_n, 1'b1);
        chk("R1 ad_oe", ad_oe, 1'b0);
        chk("R1 busy", busy, 1'b0);
        chk("R1 err/rd_valid", {err, rd_valid}, 2'b00);
        chk("R1 hi_out", hi_out, hi_gpio);
        expect_refused("R1 mode off at reset");
    endtask

    task automatic t_mode_off();
        write_cfg(8'h18, 1'b0);
        tick();
        expect_refused("R2 bit3 set");
        write_cfg(8'h02, 1'b0);
        tick();
        expect_refused("R2 bit4 clear");
    endtask

    task automatic t_guard();
        write_cfg(8'h12, 1'b0);
        expect_refused("R3 guard armed");
        tick();
        bus_cycle(1'b1, 16'hBEEF, 8'h3C, 8'h00, 2'b10);
    endtask

    task automatic t_widths();
        write_cfg(8'h11, 1'b0); tick();
        bus_cycle(1'b1, 16'h5A7E, 8'hC3, 8'h00, 2'b01);
        bus_cycle(1'b0, 16'hF0E1, 8'h00, 8'h96, 2'b01);
        write_cfg(8'h13, 1'b0); tick();
        bus_cycle(1'b0, 16'h8421, 8'h00, 8'h69, 2'b11);
        write_cfg(8'h10, 1'b0); tick();
        hi_gpio = 8'h3C;
        bus_cycle(1'b1, 16'hFFFF, 8'h11, 8'h00, 2'b00);
        hi_gpio = 8'hA5;
    endtask

    task automatic t_busy_holdoff();
        write_cfg(8'h12, 1'b0); tick();
        req_valid = 1'b1; req_we = 1'b1; req_addr = 16'h0102; req_wdata = 8'h55;
        @(negedge clk);
        req_addr = 16'h7777;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R9 no err while busy", err, 1'b0);
            chk("R9 as_n stays high", as_n, 1'b1);
        end
        req_valid = 1'b0;
        @(negedge clk);
        chk("R9 idle after one cycle", busy, 1'b0);
        chk("R9 no err after", err, 1'b0);
        @(negedge clk);
        chk("R9 no second cycle", {busy, as_n}, 2'b01);
    endtask

    task automatic t_collisions();
        write_cfg(8'h12, 1'b1);
        expect_refused("R10 tick with write");
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = 8'h12;
        req_valid = 1'b1; req_we = 1'b0; req_addr = 16'h4444;
        @(negedge clk);
        cfg_we = 1'b0; req_valid = 1'b0;
        chk("R10 req with write err", err, 1'b1);
        chk("R10 req with write no busy", busy, 1'b0);
        tick();
        bus_cycle(1'b0, 16'h2468, 8'h00, 8'h5A, 2'b10);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode_off();
        t_guard();
        t_widths();
        t_busy_holdoff();
        t_collisions();
        repeat (2) @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule